// File: doc/BRIEF.md
# Two-Level Write-Back Cache Controller

This block places two levels of cache between a processor's word-wide request port and a memory port that moves whole lines. The first level (near cache) is direct-mapped, with one line per index. The second level (far cache) is two-way set-associative and keeps one recency bit per set. Both levels hold their tags, data, valid bits and dirty bits in flip-flops. A request looks in the near cache first, then in the far cache, and only then in memory. Any line that comes from a lower level is installed in the near cache before the requested word is returned.

Both levels are write-back. A processor write changes only the near-cache copy and marks that copy dirty. When a dirty near-cache line is displaced, it is pushed down into the far cache. When a dirty far-cache line is displaced, it goes to memory as one block write, and this write is issued before the replacement block is read. The controller accepts one request at a time. For each request it returns the data and a code that says which level supplied the line.

The controller is a single state machine with nine states:
- `S_IDLE`: ready for a request. On `req_valid` it goes to `S_L1`.
- `S_L1`: near-cache probe. A hit goes to `S_RESP`. A miss goes to `S_L2`. If the near-cache victim is dirty, the controller first stages that victim for push-down.
- `S_L2`: far-cache probe of the target block.
  - A hit during push-down absorbs the victim and stays in `S_L2` to probe the requested block.
  - A hit on the requested block goes to `S_FILL`.
  - A miss with a dirty far victim goes to `S_EVICT`. Any other miss goes to `S_ALLOC`.
- `S_EVICT`: block write to memory. It leaves for `S_ALLOC` on `mem_req_ready`.
- `S_ALLOC`: during push-down, installs the victim and returns to `S_L2`. Otherwise it goes to `S_MRD`.
- `S_MRD`: block read command. It leaves for `S_MWAIT` on `mem_req_ready`.
- `S_MWAIT`: installs the returned line in the far cache and goes to `S_FILL` on `mem_rsp_valid`.
- `S_FILL`: near-cache install and write merge, then `S_RESP`.
- `S_RESP`: one response cycle, then `S_IDLE`.

Top module: `cache_ctrl`

## Requirements
- R1: After reset, every line of both levels is invalid and clean, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first access to any address therefore reports level 2.
- R2: A near-cache hit answers with `resp_level` = 0 and issues no memory command during that request.
- R3: A near-cache miss that hits the far cache copies the whole line into the near cache and answers with `resp_level` = 1, with no memory read. A later access to any other word of that line answers with level 0.
- R4: A miss in both levels issues exactly one memory read. Its `mem_req_blk` equals `req_addr[15:2]`. The request answers with `resp_level` = 2, and the line is installed in both levels.
- R5: Address bits [1:0] select the word within a 4-word line. Bits [4:2] select the near-cache line and the far-cache set, and bits [15:5] form the tag. Two blocks 32 words apart therefore conflict in the near cache but can share one far-cache set, and an access to another index leaves a resident line in place.
- R6: A processor write changes only the cache and marks the line dirty. The write itself causes no memory write. `resp_rdata` echoes the written word.
- R7: A dirty near-cache victim is written into the far cache, and this push-down causes no memory traffic. A later read of that data returns the written value with level 1.
- R8: The far-cache victim is an invalid way if one exists, otherwise the way not touched most recently. Every far-cache hit and every fill marks the touched way as most recent.
- R9: A dirty far-cache victim is sent to memory as one block write, with word 0 in bits [31:0]. It is sent before the memory read for the new block is issued.
- R10: `req_ready` is 0 from the cycle after acceptance until the response. `resp_valid` is a one-cycle pulse and never coincides with `req_ready`.
- R11: Once asserted, `mem_req_valid`, `mem_req_write`, `mem_req_blk` and `mem_req_wline` hold steady until `mem_req_ready` completes the handshake.
- R12: Every read returns the value of the most recent write to that address, or the memory contents if the address was never written. `resp_level` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 32 | Read data, or the echoed write data |
| resp_level | output | 2 | 0 = near hit, 1 = far hit, 2 = memory fill |
| mem_req_valid | output | 1 | Memory command present |
| mem_req_ready | input | 1 | Memory accepts the command |
| mem_req_write | output | 1 | 1 = block write, 0 = block read |
| mem_req_blk | output | 14 | Block number (word address / 4) |
| mem_req_wline | output | 128 | Block write data, word i in bits [32i+31:32i] |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_line | input | 128 | Returned line, same word packing |

## Verification
The assertions check the following on every cycle:
- the request and response handshake rules;
- that a memory command holds steady until it is accepted;
- that the level code agrees with the memory traffic of the same request: no traffic on a near hit, no read on a far hit, exactly one read on a fill;
- that a block write never follows a read within one request.

Only the bench scenarios can show:
- which way is displaced according to recency;
- that pushed-down dirty data survives and later reaches memory with the right contents;
- that read data matches the flat reference memory across long random mixes of reads and writes.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_L1, S_L2, S_EVICT, S_ALLOC, S_MRD, S_MWAIT, S_FILL, S_RESP
    } state_t;

    localparam logic [1:0] LVL_NEAR = 2'd0;
    localparam logic [1:0] LVL_FAR  = 2'd1;
    localparam logic [1:0] LVL_MEM  = 2'd2;
endpackage

// File: rtl/l1_store.sv
module l1_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 11,
    parameter int LINE_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     hit,
    output logic                     vic_dirty,
    output logic [TAG_W-1:0]         vic_tag,
    output logic [LINE_W-1:0]        line,
    input  logic                     wr_en,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [LINE_W-1:0]        wr_line,
    input  logic                     wr_dirty
);
    logic [LINES-1:0]  vld;
    logic [LINES-1:0]  drt;
    logic [TAG_W-1:0]  tags [LINES];
    logic [LINE_W-1:0] data [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            drt <= '0;
        end else if (wr_en) begin
            vld[idx] <= 1'b1;
            drt[idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[idx] <= wr_tag;
            data[idx] <= wr_line;
        end
    end

    assign hit       = vld[idx] && (tags[idx] == lk_tag);
    assign vic_dirty = vld[idx] && drt[idx];
    assign vic_tag   = tags[idx];
    assign line      = data[idx];
endmodule

// File: rtl/l2_store.sv
module l2_store #(
    parameter int SETS   = 8,
    parameter int TAG_W  = 11,
    parameter int LINE_W = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] set,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    hit,
    output logic                    hit_way,
    output logic [LINE_W-1:0]       hit_line,
    output logic                    vic_way,
    output logic                    vic_dirty,
    output logic [TAG_W-1:0]        vic_tag,
    output logic [LINE_W-1:0]       vic_line,
    input  logic                    wr_en,
    input  logic                    wr_way,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic                    wr_dirty,
    input  logic                    touch_en,
    input  logic                    touch_way
);
    localparam int WAYS = 2;

    logic [SETS-1:0]   vld  [WAYS];
    logic [SETS-1:0]   drt  [WAYS];
    logic [TAG_W-1:0]  tags [WAYS][SETS];
    logic [LINE_W-1:0] data [WAYS][SETS];
    logic [SETS-1:0]   lru;
    logic [WAYS-1:0]   way_hit;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign way_hit[w] = vld[w][set] && (tags[w][set] == lk_tag);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                vld[w] <= '0;
                drt[w] <= '0;
            end
            lru <= '0;
        end else begin
            if (wr_en) begin
                vld[wr_way][set] <= 1'b1;
                drt[wr_way][set] <= wr_dirty;
            end
            if (touch_en) lru[set] <= ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_way][set] <= wr_tag;
            data[wr_way][set] <= wr_line;
        end
    end

    assign hit       = |way_hit;
    assign hit_way   = way_hit[1];
    assign hit_line  = data[hit_way][set];
    assign vic_way   = !vld[0][set] ? 1'b0 : (!vld[1][set] ? 1'b1 : lru[set]);
    assign vic_dirty = vld[vic_way][set] && drt[vic_way][set];
    assign vic_tag   = tags[vic_way][set];
    assign vic_line  = data[vic_way][set];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 4,
    parameter int L1_LINES = 8,
    parameter int L2_SETS  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [DATA_W-1:0]                   req_wdata,
    output logic                                resp_valid,
    output logic [DATA_W-1:0]                   resp_rdata,
    output logic [1:0]                          resp_level,
    output logic                                mem_req_valid,
    input  logic                                mem_req_ready,
    output logic                                mem_req_write,
    output logic [ADDR_W-$clog2(WORDS)-1:0]     mem_req_blk,
    output logic [DATA_W*WORDS-1:0]             mem_req_wline,
    input  logic                                mem_rsp_valid,
    input  logic [DATA_W*WORDS-1:0]             mem_rsp_line
);
    localparam int OFF_W    = $clog2(WORDS);
    localparam int BLK_W    = ADDR_W - OFF_W;
    localparam int L1_IDX_W = $clog2(L1_LINES);
    localparam int L1_TAG_W = BLK_W - L1_IDX_W;
    localparam int L2_SET_W = $clog2(L2_SETS);
    localparam int L2_TAG_W = BLK_W - L2_SET_W;
    localparam int LINE_W   = DATA_W * WORDS;

    state_t              state, nxt;
    logic [ADDR_W-1:0]   addr_q;
    logic                wr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [1:0]          lvl_q;
    logic                wb_q;
    logic [BLK_W-1:0]    tgt_blk_q;
    logic [LINE_W-1:0]   wb_line_q;
    logic [LINE_W-1:0]   line_q;
    logic                way_q;
    logic [BLK_W-1:0]    ev_blk_q;
    logic [LINE_W-1:0]   ev_line_q;

    logic [OFF_W-1:0]    off;
    logic [L1_IDX_W-1:0] l1_idx;
    logic [L1_TAG_W-1:0] l1_tag;
    logic [BLK_W-1:0]    req_blk;
    logic [L2_SET_W-1:0] l2_set;
    logic [L2_TAG_W-1:0] l2_tag;

    logic                l1_hit, l1_vic_dirty;
    logic [L1_TAG_W-1:0] l1_vic_tag;
    logic [LINE_W-1:0]   l1_line;
    logic                l1_wr_en, l1_wr_dirty;
    logic [LINE_W-1:0]   l1_wr_line;

    logic                l2_hit, l2_hit_way, l2_vic_way, l2_vic_dirty;
    logic [LINE_W-1:0]   l2_hit_line, l2_vic_line;
    logic [L2_TAG_W-1:0] l2_vic_tag;
    logic                l2_wr_en, l2_wr_way, l2_wr_dirty, l2_touch;
    logic [LINE_W-1:0]   l2_wr_line;

    function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                               input logic [OFF_W-1:0] o);
        return ln[o*DATA_W +: DATA_W];
    endfunction

    function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] o,
                                                input logic [DATA_W-1:0] d);
        logic [LINE_W-1:0] r;
        r = ln;
        r[o*DATA_W +: DATA_W] = d;
        return r;
    endfunction

    assign off     = addr_q[OFF_W-1:0];
    assign l1_idx  = addr_q[OFF_W +: L1_IDX_W];
    assign l1_tag  = addr_q[ADDR_W-1 -: L1_TAG_W];
    assign req_blk = addr_q[ADDR_W-1:OFF_W];
    assign l2_set  = tgt_blk_q[L2_SET_W-1:0];
    assign l2_tag  = tgt_blk_q[BLK_W-1:L2_SET_W];

    l1_store #(.LINES(L1_LINES), .TAG_W(L1_TAG_W), .LINE_W(LINE_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .idx(l1_idx), .lk_tag(l1_tag),
        .hit(l1_hit), .vic_dirty(l1_vic_dirty), .vic_tag(l1_vic_tag), .line(l1_line),
        .wr_en(l1_wr_en), .wr_tag(l1_tag), .wr_line(l1_wr_line), .wr_dirty(l1_wr_dirty)
    );

    l2_store #(.SETS(L2_SETS), .TAG_W(L2_TAG_W), .LINE_W(LINE_W)) u_l2 (
        .clk(clk), .rst_n(rst_n), .set(l2_set), .lk_tag(l2_tag),
        .hit(l2_hit), .hit_way(l2_hit_way), .hit_line(l2_hit_line),
        .vic_way(l2_vic_way), .vic_dirty(l2_vic_dirty), .vic_tag(l2_vic_tag),
        .vic_line(l2_vic_line),
        .wr_en(l2_wr_en), .wr_way(l2_wr_way), .wr_tag(l2_tag), .wr_line(l2_wr_line),
        .wr_dirty(l2_wr_dirty), .touch_en(l2_touch), .touch_way(l2_wr_way)
    );

    // State register and the push-down phase flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wb_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_L1 && !l1_hit)                  wb_q <= l1_vic_dirty;
            else if (state == S_L2 && l2_hit && wb_q)      wb_q <= 1'b0;
            else if (state == S_ALLOC)                     wb_q <= 1'b0;
        end
    end

    // Datapath holding registers
    always_ff @(posedge clk) begin
        unique case (state)
            S_IDLE: if (req_valid) begin
                addr_q  <= req_addr;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            S_L1: if (l1_hit) begin
                rdata_q <= wr_q ? wdata_q : pick(l1_line, off);
                lvl_q   <= LVL_NEAR;
            end else begin
                tgt_blk_q <= l1_vic_dirty ? {l1_vic_tag, l1_idx} : req_blk;
                wb_line_q <= l1_line;
            end
            S_L2: if (l2_hit) begin
                if (wb_q) tgt_blk_q <= req_blk;
                else begin
                    line_q <= l2_hit_line;
                    lvl_q  <= LVL_FAR;
                end
            end else begin
                way_q     <= l2_vic_way;
                ev_blk_q  <= {l2_vic_tag, l2_set};
                ev_line_q <= l2_vic_line;
            end
            S_ALLOC: if (wb_q) tgt_blk_q <= req_blk;
            S_MWAIT: if (mem_rsp_valid) begin
                line_q <= mem_rsp_line;
                lvl_q  <= LVL_MEM;
            end
            S_FILL: rdata_q <= wr_q ? wdata_q : pick(line_q, off);
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid) nxt = S_L1;
            S_L1:    nxt = l1_hit ? S_RESP : S_L2;
            S_L2:    if (l2_hit) nxt = wb_q ? S_L2 : S_FILL;
                     else        nxt = l2_vic_dirty ? S_EVICT : S_ALLOC;
            S_EVICT: if (mem_req_ready) nxt = S_ALLOC;
            S_ALLOC: nxt = wb_q ? S_L2 : S_MRD;
            S_MRD:   if (mem_req_ready) nxt = S_MWAIT;
            S_MWAIT: if (mem_rsp_valid) nxt = S_FILL;
            S_FILL:  nxt = S_RESP;
            S_RESP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs and array controls
    always_comb begin
        req_ready     = (state == S_IDLE);
        resp_valid    = (state == S_RESP);
        resp_rdata    = rdata_q;
        resp_level    = lvl_q;
        mem_req_valid = (state == S_EVICT) || (state == S_MRD);
        mem_req_write = (state == S_EVICT);
        mem_req_blk   = (state == S_EVICT) ? ev_blk_q : tgt_blk_q;
        mem_req_wline = ev_line_q;

        l1_wr_en    = (state == S_FILL) || (state == S_L1 && l1_hit && wr_q);
        l1_wr_dirty = (state == S_FILL) ? wr_q : 1'b1;
        if (state == S_FILL) l1_wr_line = wr_q ? merge(line_q, off, wdata_q) : line_q;
        else                 l1_wr_line = merge(l1_line, off, wdata_q);

        l2_wr_en    = (state == S_L2 && l2_hit && wb_q) || (state == S_ALLOC && wb_q)
                    || (state == S_MWAIT && mem_rsp_valid);
        l2_wr_way   = (state == S_L2) ? l2_hit_way : way_q;
        l2_wr_line  = (state == S_MWAIT) ? mem_rsp_line : wb_line_q;
        l2_wr_dirty = (state != S_MWAIT);
        l2_touch    = l2_wr_en || (state == S_L2 && l2_hit && !wb_q);
    end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
    parameter int BLK_W  = 14,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_level,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [BLK_W-1:0]  mem_req_blk,
    input logic [LINE_W-1:0] mem_req_wline
);
    logic [1:0] rd_cnt;
    logic       wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            wr_seen <= 1'b0;
        end else if (req_valid && req_ready) begin
            rd_cnt  <= '0;
            wr_seen <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write)       wr_seen <= 1'b1;
            else if (rd_cnt != 2'd3) rd_cnt  <= rd_cnt + 2'd1;
        end
    end

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r10_resp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_blk) && $stable(mem_req_wline));
    a_r2_near_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_level == 2'd0 |-> rd_cnt == 2'd0 && !wr_seen);
    a_r3_far_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_level == 2'd1 |-> rd_cnt == 2'd0);
    a_r4_fill_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_level == 2'd2 |-> rd_cnt == 2'd1);
    a_r9_write_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> rd_cnt == 2'd0);
    a_r12_level_code: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_level != 2'd3);
endmodule

bind cache_ctrl cache_ctrl_chk #(
    .BLK_W(ADDR_W - $clog2(WORDS)),
    .LINE_W(DATA_W * WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_level(resp_level),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_blk(mem_req_blk),
    .mem_req_wline(mem_req_wline)
);

// File: tb/cache_ctrl_tb.sv
module cache_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write;
    logic [15:0]  req_addr;
    logic [31:0]  req_wdata;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic [1:0]   resp_level;
    logic         mem_req_valid, mem_req_ready, mem_req_write;
    logic [13:0]  mem_req_blk;
    logic [127:0] mem_req_wline;
    logic         mem_rsp_valid;
    logic [127:0] mem_rsp_line;

    always #2 clk = ~clk;

    cache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_level(resp_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_blk(mem_req_blk),
        .mem_req_wline(mem_req_wline), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_line(mem_rsp_line)
    );

    int n_tests = 0, n_fail = 0;
    int mem_rd_n = 0, mem_wr_n = 0, hold_bad = 0, spur = 0;
    bit pending = 0;
    logic [13:0]  last_rd_blk, last_wr_blk, r_blk;
    logic         r_w;
    logic [127:0] r_line;
    logic [31:0]  mmem [int];
    logic [31:0]  rmem [int];

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction
    function automatic logic [31:0] mget(input int a);
        return mmem.exists(a) ? mmem[a] : pat(a);
    endfunction
    function automatic logic [31:0] rget(input int a);
        return rmem.exists(a) ? rmem[a] : pat(a);
    endfunction

    task automatic check(input bit ok, input string r, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Memory responder: waits one cycle before accepting, 2-cycle read latency
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_line  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                r_blk = mem_req_blk; r_w = mem_req_write; r_line = mem_req_wline;
                @(negedge clk);
                if (!mem_req_valid || mem_req_blk != r_blk || mem_req_write != r_w
                    || mem_req_wline != r_line) hold_bad++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (r_w) begin
                    for (int i = 0; i < 4; i++) mmem[int'(r_blk) * 4 + i] = r_line[i*32 +: 32];
                    mem_wr_n++;
                    last_wr_blk = r_blk;
                end else begin
                    repeat (2) @(negedge clk);
                    for (int i = 0; i < 4; i++) mem_rsp_line[i*32 +: 32] = mget(int'(r_blk) * 4 + i);
                    mem_rsp_valid = 1'b1;
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                    mem_rd_n++;
                    last_rd_blk = r_blk;
                end
            end
        end
    end

    // Per-clock monitor: no response outside an outstanding request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !pending && resp_valid) spur++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d,
                          input int exp_lvl, input string r,
                          output logic [1:0] lvl, output int rds, output int wrs);
        int rd0, wr0, cyc;
        logic [31:0] exp;
        rd0 = mem_rd_n; wr0 = mem_wr_n;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; pending = 1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready while busy", 32'(req_ready), 32'd0);
        cyc = 0;
        while (!resp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(resp_valid == 1'b1, "R10", "response timeout", 32'(resp_valid), 32'd1);
        exp = w ? d : rget(int'(a));
        if (w) rmem[int'(a)] = d;
        check(resp_rdata == exp, w ? "R6" : "R12", "data", resp_rdata, exp);
        if (exp_lvl >= 0)
            check(resp_level == 2'(exp_lvl), r, "level", 32'(resp_level), 32'(exp_lvl));
        lvl = resp_level;
        rds = mem_rd_n - rd0;
        wrs = mem_wr_n - wr0;
        @(negedge clk);
        pending = 0;
    endtask

    localparam logic [15:0] A = 16'h0104;   // index 1
    localparam logic [15:0] B = A + 16'd32; // same index and set as A
    localparam logic [15:0] C = A + 16'd64; // same again
    localparam logic [15:0] D = 16'h0108;   // index 2

    initial begin
        logic [1:0] lv;
        int rd, wr;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "idle outputs",
              32'({resp_valid, mem_req_valid}), 32'd0);

        // R1/R4 cold read fills from memory
        access(0, A, 0, 2, "R4", lv, rd, wr);
        check(rd == 1 && wr == 0, "R4", "one memory read", 32'(rd), 32'd1);
        check(last_rd_blk == A[15:2], "R4", "read block number", 32'(last_rd_blk), 32'(A[15:2]));
        // R2/R5 same line, other word
        access(0, A + 16'd1, 0, 0, "R2", lv, rd, wr);
        check(rd == 0 && wr == 0, "R2", "no memory traffic on near hit", 32'(rd + wr), 32'd0);
        // R6 write hit
        access(1, A + 16'd2, 32'hDEAD_BEEF, 0, "R6", lv, rd, wr);
        check(wr == 0, "R6", "write causes no memory write", 32'(wr), 32'd0);
        // R7/R5 conflicting block pushes dirty line to far cache
        access(0, B, 0, 2, "R5", lv, rd, wr);
        check(rd == 1 && wr == 0, "R7", "push-down without memory write", 32'(wr), 32'd0);
        check(mget(int'(A) + 2) == pat(int'(A) + 2), "R6", "memory still stale",
              mget(int'(A) + 2), pat(int'(A) + 2));
        // R3/R7 far hit returns written data
        access(0, A + 16'd2, 0, 1, "R3", lv, rd, wr);
        check(rd == 0, "R3", "no read on far hit", 32'(rd), 32'd0);
        access(0, A + 16'd3, 0, 0, "R3", lv, rd, wr);
        // R8 recency: B displaced (clean)
        access(0, C, 0, 2, "R8", lv, rd, wr);
        check(wr == 0, "R8", "clean victim not written", 32'(wr), 32'd0);
        // R8/R9 B returns from memory, dirty A displaced and written first
        access(0, B, 0, 2, "R8", lv, rd, wr);
        check(wr == 1 && rd == 1, "R9", "one block write then read", 32'(wr), 32'd1);
        check(last_wr_blk == A[15:2], "R9", "written block", 32'(last_wr_blk), 32'(A[15:2]));
        check(mget(int'(A) + 2) == 32'hDEAD_BEEF, "R9", "word 2 of write-back",
              mget(int'(A) + 2), 32'hDEAD_BEEF);
        check(mget(int'(A)) == pat(int'(A)), "R9", "word 0 of write-back",
              mget(int'(A)), pat(int'(A)));
        // R5 other index leaves B resident
        access(0, D, 0, 2, "R5", lv, rd, wr);
        access(0, B + 16'd1, 0, 0, "R5", lv, rd, wr);

        // R12 random mix over 64 blocks
        for (int k = 0; k < 300; k++) begin
            logic [15:0] ra;
            bit rw;
            ra = 16'h0100 + 16'($urandom_range(0, 255));
            rw = ($urandom_range(0, 9) < 4);
            access(rw, ra, $urandom, -1, "R12", lv, rd, wr);
            check(lv != 2'd3, "R12", "level code", 32'(lv), 32'd2);
            check((lv == 2'd2) == (rd == 1), "R4", "fill iff one read", 32'(rd), 32'(lv == 2'd2));
            if (lv == 2'd0) check(wr == 0 && rd == 0, "R2", "near hit quiet", 32'(rd + wr), 32'd0);
        end
        for (int k = 0; k < 256; k++) begin
            access(0, 16'h0100 + 16'(k), 0, -1, "R12", lv, rd, wr);
        end

        check(hold_bad == 0, "R11", "command held until accepted", 32'(hold_bad), 32'd0);
        check(spur == 0, "R10", "spurious responses", 32'(spur), 32'd0);
        finish_run();
    end
endmodule